// File: doc/BRIEF.md
# Programmable Read-Only Memory Mode Decoder

This block is a synthesizable, clocked model of a 16-bit-wide one-time-writable memory. Five control inputs select its operating mode: an active-low chip select, an active-low output gate, an active-low write strobe, a flag meaning the programming supply is at its high level, and a flag meaning the identify level is present on address bit 9. The data port is split into an input bus, an output bus and an output-enable. An outer pad ring or a bench resolves these into one bidirectional bus.

On every rising clock edge the decoder classifies the inputs into one of six modes: standby, output disabled, read, identify, program or verify. It then registers the output word and its enable, so all outputs appear one cycle after the inputs that cause them. The storage array starts at all ones. A program cycle can only clear bits, because the stored word becomes its old value ANDed with the input word. The identify mode returns one of two fixed 8-bit codes with odd parity, and address bit 0 selects between them. The array is a small parameterised register file indexed by the low address bits, so the model stays testable. Upper address bits alias onto it.

Top module: `eprom_model`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0 and `vpp_hi`=0, and identify not selected, the cycle after the edge gives `dq_oe`=1 and `dq_out` equal to the word at index `addr[MEM_AW-1:0]`. Upper address bits alias onto this index.
- R2: With `ce_n`=0 and `oe_n`=1, and the inputs not forming a program cycle, `dq_oe` is 0 in the next cycle, whatever `vpp_hi`, `id_hi` and `pgm_n` are.
- R3: With `ce_n`=1, `dq_oe` is 0 in the next cycle whatever the other inputs are. A write strobe under the programming supply leaves the array unchanged in this state.
- R4: With `vpp_hi`=1, `ce_n`=0 and `pgm_n`=0, the edge is a program cycle. The addressed word is replaced by (stored AND `dq_in`), and `dq_oe` is 0 in the next cycle.
- R5: With `vpp_hi`=1, `ce_n`=0, `pgm_n`=1 and `oe_n`=0, the stored word is driven with `dq_oe`=1, and `id_hi` is ignored.
- R6: With `vpp_hi`=0, `id_hi`=1, `ce_n`=0, `oe_n`=0 and `addr[16:1]` all zero, the output is 16'h0001 when `addr[0]`=0 and 16'h0098 when `addr[0]`=1.
- R7: Every identify code has bits 15..8 at zero and an odd number of ones in bits 7..0, with bit 7 serving as the parity bit.
- R8: After reset `dq_oe` is 0 and every array word reads 16'hFFFF.
- R9: Programming only clears bits. Repeating a program cycle with the same data does nothing more, and programming with all ones leaves the word unchanged.
- R10: With the identify flag set but any of `addr[16:1]` nonzero, a read returns the array word and not a code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every mode is evaluated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; fills the array with ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low write strobe |
| vpp_hi | input | 1 | Programming supply at its high level |
| id_hi | input | 1 | Identify level present on address bit 9 |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Word to program |
| dq_out | output | DATA_W | Word read, verified or identified |
| dq_oe | output | 1 | High when `dq_out` should drive the bus |

## Verification
Identify mode is the hardest state to reach by chance: it needs the identify flag, a low supply flag and sixteen address bits all at zero at the same time, so uniform random addresses almost never hit it. The random stimulus therefore forces a third of its addresses to the form {zeros, a0}. This makes both codes frequent, and the rest of the addresses still test the R10 fallback. A second hard state is an inhibited write, where `ce_n` is high while the strobe and supply are active. It leaves no trace on the ports until a later read of the same word, so the directed sequence follows each inhibited write with a read-back. Random write data is ORed from three draws, which keeps the array from collapsing to zero too early.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_DISABLE,
        MODE_READ,
        MODE_IDENT,
        MODE_PROGRAM,
        MODE_VERIFY
    } mode_e;

    // Prefix a 7-bit payload with the bit that makes the byte's ones count odd.
    function automatic logic [7:0] odd_parity_byte(input logic [6:0] payload);
        return {~^payload, payload};
    endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic [ADDR_W-1:0] addr,
    output mode_e             mode
);

    logic upper_zero;

    assign upper_zero = (addr[ADDR_W-1:1] == '0);

    // Order matters: deselect wins, then a write strobe, then the output gate.
    always_comb begin
        if (ce_n) begin
            mode = MODE_STANDBY;
        end else if (vpp_hi && !pgm_n) begin
            mode = MODE_PROGRAM;
        end else if (oe_n) begin
            mode = MODE_DISABLE;
        end else if (vpp_hi) begin
            mode = MODE_VERIFY;
        end else if (id_hi && upper_zero) begin
            mode = MODE_IDENT;
        end else begin
            mode = MODE_READ;
        end
    end

endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom
    import eprom_pkg::*;
#(
    parameter int         DATA_W      = 16,
    parameter logic [6:0] MFR_PAYLOAD = 7'h01,
    parameter logic [6:0] DEV_PAYLOAD = 7'h18
) (
    input  logic              sel,
    output logic [DATA_W-1:0] code
);

    localparam logic [7:0] MFR_BYTE = odd_parity_byte(MFR_PAYLOAD);
    localparam logic [7:0] DEV_BYTE = odd_parity_byte(DEV_PAYLOAD);

    always_comb begin
        code = '0;
        code[7:0] = sel ? DEV_BYTE : MFR_BYTE;
    end

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int DATA_W = 16,
    parameter int MEM_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DEPTH-1:0]  hit;

    for (genvar w = 0; w < DEPTH; w++) begin : g_hit
        assign hit[w] = wr_en && (idx == MEM_AW'(w));
    end

    // A write can only pull bits low: the new word is old AND incoming.
    always_comb begin
        for (int w = 0; w < DEPTH; w++) begin
            mem_d[w] = hit[w] ? (mem_q[w] & wdata) : mem_q[w];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= '1;
            end
        end else begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= mem_d[w];
            end
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int         ADDR_W      = 17,
    parameter int         DATA_W      = 16,
    parameter int         MEM_AW      = 5,
    parameter logic [6:0] MFR_PAYLOAD = 7'h01,
    parameter logic [6:0] DEV_PAYLOAD = 7'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] dq;
    } port_s;

    mode_e             mode;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] id_word;
    logic              wr_en;
    port_s             port_d;
    port_s             port_q;

    eprom_mode_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .id_hi  (id_hi),
        .addr   (addr),
        .mode   (mode)
    );

    assign wr_en = (mode == MODE_PROGRAM);

    eprom_array #(
        .DATA_W (DATA_W),
        .MEM_AW (MEM_AW)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .idx    (addr[MEM_AW-1:0]),
        .wdata  (dq_in),
        .rdata  (arr_word)
    );

    eprom_id_rom #(
        .DATA_W      (DATA_W),
        .MFR_PAYLOAD (MFR_PAYLOAD),
        .DEV_PAYLOAD (DEV_PAYLOAD)
    ) u_id (
        .sel  (addr[0]),
        .code (id_word)
    );

    always_comb begin
        port_d = '0;
        case (mode)
            MODE_READ, MODE_VERIFY: begin
                port_d.oe = 1'b1;
                port_d.dq = arr_word;
            end
            MODE_IDENT: begin
                port_d.oe = 1'b1;
                port_d.dq = id_word;
            end
            default: begin
                port_d.oe = 1'b0;
                port_d.dq = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign dq_out = port_q.dq;
    assign dq_oe  = port_q.oe;

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
    parameter int         ADDR_W   = 17,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] MFR_BYTE = 8'h01,
    parameter logic [7:0] DEV_BYTE = 8'h98
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              id_hi,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    logic armed_q;
    logic ident_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign ident_now = !ce_n && !oe_n && !vpp_hi && id_hi && (addr[ADDR_W-1:1] == '0);

    AST_STANDBY_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(ce_n) |-> !dq_oe);  // R3

    AST_PROGRAM_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(!ce_n && vpp_hi && !pgm_n) |-> !dq_oe);  // R4

    AST_GATE_OFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(!ce_n && oe_n) |-> !dq_oe);  // R2

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(!ce_n && !oe_n && !(vpp_hi && !pgm_n)) |-> dq_oe);  // R1

    AST_ID_MFR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(ident_now && !addr[0]) |-> dq_out == DATA_W'(MFR_BYTE));  // R6

    AST_ID_DEV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(ident_now && addr[0]) |-> dq_out == DATA_W'(DEV_BYTE));  // R6

    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(ident_now) |-> (^dq_out[7:0]) && (dq_out[DATA_W-1:8] == '0));  // R7

endmodule

bind eprom_model eprom_model_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_hi (vpp_hi),
    .id_hi  (id_hi),
    .addr   (addr),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/tb_eprom_model.sv
`timescale 1ns/1ps
module tb_eprom_model;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 16;
    localparam int MEM_AW = 5;
    localparam int DEPTH  = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] dq_in = '0;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DATA_W-1:0] mdl [DEPTH];

    always #2.5 clk = ~clk;

    eprom_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .id_hi(id_hi), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [DATA_W:0] act,
                       input logic [DATA_W:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual oe/dq=%h expected oe/dq=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, predict, advance to the next falling edge, compare.
    task automatic step(input logic c, input logic o, input logic p, input logic v,
                        input logic i, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input string tag);
        logic              e_oe;
        logic [DATA_W-1:0] e_dq;
        string             req;
        ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hi = i; addr = a; dq_in = d;
        e_oe = 1'b0; e_dq = '0;
        if (c) begin
            req = "R3";
        end else if (v && !p) begin
            req = "R4";
            mdl[a[MEM_AW-1:0]] = mdl[a[MEM_AW-1:0]] & d;
        end else if (o) begin
            req = "R2";
        end else if (v) begin
            req = "R5"; e_oe = 1'b1; e_dq = mdl[a[MEM_AW-1:0]];
        end else if (i && a[ADDR_W-1:1] == '0) begin
            req = "R6"; e_oe = 1'b1; e_dq = a[0] ? 16'h0098 : 16'h0001;
        end else begin
            req = i ? "R10" : "R1"; e_oe = 1'b1; e_dq = mdl[a[MEM_AW-1:0]];
        end
        if (tag != "") req = tag;
        @(negedge clk);
        chk((dq_oe == e_oe) && (!e_oe || dq_out == e_dq), req, {dq_oe, dq_out}, {e_oe, e_dq});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) mdl[k] = '1;
        void'($urandom(32'h5EED_2048));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: output disabled straight out of reset, array all ones
        chk(dq_oe == 1'b0, "R8", {dq_oe, dq_out}, '0);
        for (int k = 0; k < DEPTH; k++) step(0, 0, 1, 0, 0, ADDR_W'(k), '0, "R8");

        // R4/R5/R9: program, verify, repeated and all-ones pulses
        step(0, 1, 0, 1, 0, 17'd3, 16'hA5F0, "R4");
        step(0, 0, 1, 1, 0, 17'd3, '0, "R5");
        step(0, 1, 0, 1, 0, 17'd3, 16'hFF0F, "R9");
        step(0, 0, 1, 1, 0, 17'd3, '0, "R9");
        step(0, 1, 0, 1, 0, 17'd3, 16'hFF0F, "R9");
        step(0, 1, 0, 1, 0, 17'd3, 16'hFFFF, "R9");
        step(0, 0, 1, 1, 0, 17'd3, '0, "R9");
        step(0, 0, 1, 1, 1, 17'd3, '0, "R5");

        // R3: deselected write attempt leaves the word, then read back
        step(1, 0, 0, 1, 0, 17'd7, 16'h0000, "R3");
        step(0, 0, 1, 0, 0, 17'd7, '0, "R3");
        step(1, 0, 1, 0, 1, 17'd0, '0, "R3");

        // R2: output gate high in both supply states
        step(0, 1, 1, 0, 0, 17'd3, '0, "R2");
        step(0, 1, 1, 1, 1, 17'd3, '0, "R2");

        // R6/R7: identify codes and their parity
        step(0, 0, 1, 0, 1, 17'd0, '0, "R6");
        chk(^dq_out[7:0] && dq_out[15:8] == 8'h00, "R7", {dq_oe, dq_out}, {1'b1, 16'h0001});
        step(0, 0, 1, 0, 1, 17'd1, '0, "R6");
        chk(^dq_out[7:0] && dq_out[15:8] == 8'h00, "R7", {dq_oe, dq_out}, {1'b1, 16'h0098});

        // R10: identify flag with upper bits set falls back to the array
        step(0, 0, 1, 0, 1, 17'h00023, '0, "R10");
        step(0, 0, 1, 0, 1, 17'h10000, '0, "R10");

        // R1: aliasing of upper address bits onto the array index
        step(0, 0, 1, 0, 0, 17'h00043, '0, "R1");

        for (int n = 0; n < 3000; n++) begin
            logic [ADDR_W-1:0] a;
            a = ($urandom % 3 == 0) ? ADDR_W'($urandom % 2) : ADDR_W'($urandom);
            step(($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 8) != 0,
                 ($urandom % 3) == 0, ($urandom % 3) == 0, a,
                 DATA_W'($urandom | $urandom | $urandom), "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule